// File: doc/BRIEF.md
# Bit-Serial Adder with Gate-Built JK Carry

This block adds two unsigned words one bit position per clock. A load strobe captures the augend and addend into two right-shifting registers and clears the carry. Each enabled cycle then takes the low bit of both registers and forms a sum bit from those two bits and the stored carry. The sum bit enters the augend register at its top end, so after WIDTH enabled cycles that register holds the complete sum in place of the augend.

The carry is held in a single flip-flop that behaves as a JK type built from plain gates. J is set when both operand bits are one. K is set when both are zero. When the bits differ, J and K are both low and the carry keeps its value. A counter tracks the bit positions. When the last position has been added, a done flag rises, and further shift requests are ignored until the next load.

Top module: `serial_jk_adder`

## Requirements
- R1: Synchronous reset, active high, clears sum_word, carry_out and done to 0 at the next rising edge.
- R2: A cycle with load high captures augend_in into sum_word and addend_in into the internal addend register. It also clears carry_out and done. All of these are visible after that edge.
- R3: Exactly WIDTH shift-enabled cycles after a load, done reads 1, sum_word equals (augend+addend) mod 2^WIDTH, and carry_out equals bit WIDTH of the full sum.
- R4: sum_bit is combinational. It equals the XOR of the augend register's bit 0, the addend register's bit 0 and carry_out, so the first bit time after a load gives augend_in[0] XOR addend_in[0].
- R5: A cycle with load, shift_en and rst all low leaves sum_word, carry_out and done unchanged.
- R6: After k shift cycles, carry_out equals bit k of the sum of the low k bits of both operands. J = x AND y sets it, K = NOR(x, y) clears it, and differing bits hold it.
- R7: While done is 1, shift_en has no effect: sum_word and carry_out stay unchanged.
- R8: Each shift cycle moves sum_word right by one, with the new sum bit entering bit WIDTH-1. After k shifts, bits WIDTH-1 down to WIDTH-k hold the low k sum bits, and the remaining bits hold augend>>k.
- R9: When load and shift_en are both high, load takes priority and no shift occurs in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture operands, clear carry and done |
| augend_in | input | WIDTH | First operand |
| addend_in | input | WIDTH | Second operand |
| shift_en | input | 1 | Process one bit position |
| sum_word | output | WIDTH | Augend register; holds the sum once done |
| sum_bit | output | 1 | Current serial sum bit |
| carry_out | output | 1 | Carry flip-flop state |
| done | output | 1 | All WIDTH bit positions added |

## Verification
The bench builds the block at its default WIDTH of 8. With that width, all-ones operands drive a carry chain through every bit, and the counter has to reach its terminal value. Random operands run with random idle gaps inserted between shifts. The bench compares the partially shifted word and the carry after every bit time. Directed pairs cover zero plus zero, a carry that runs through all positions, alternating patterns that never generate a carry, and a load issued together with a shift request.

// File: rtl/serial_jk_adder.sv
module serial_jk_adder #(
  parameter int WIDTH = 8,
  localparam int CW = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] augend_in,
  input  logic [WIDTH-1:0] addend_in,
  input  logic             shift_en,
  output logic [WIDTH-1:0] sum_word,
  output logic             sum_bit,
  output logic             carry_out,
  output logic             done
);

  logic [WIDTH-1:0] aug_q, add_q;
  logic [CW-1:0]    steps_q;
  logic             cy_q, done_q;
  logic             x, y, jin, kin, cy_next, step;
  logic [WIDTH:0]   aug_sh;

  assign x       = aug_q[0];
  assign y       = add_q[0];
  assign jin     = x & y;
  assign kin     = ~(x | y);
  assign cy_next = (jin & ~cy_q) | (~kin & cy_q);
  assign sum_bit = x ^ y ^ cy_q;
  assign step    = shift_en & ~load & ~done_q;
  assign aug_sh  = {sum_bit, aug_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      aug_q   <= '0;
      add_q   <= '0;
      cy_q    <= 1'b0;
      steps_q <= '0;
      done_q  <= 1'b0;
    end else if (load) begin
      aug_q   <= augend_in;
      add_q   <= addend_in;
      cy_q    <= 1'b0;
      steps_q <= '0;
      done_q  <= 1'b0;
    end else if (step) begin
      aug_q   <= aug_sh[WIDTH:1];
      add_q   <= add_q >> 1;
      cy_q    <= cy_next;
      steps_q <= steps_q + 1'b1;
      done_q  <= (steps_q == CW'(WIDTH - 1));
    end
  end

  assign sum_word  = aug_q;
  assign carry_out = cy_q;
  assign done      = done_q;

endmodule

// File: rtl/serial_jk_adder_chk.sv
module serial_jk_adder_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic             shift_en,
  input logic [WIDTH-1:0] augend_in,
  input logic [WIDTH-1:0] sum_word,
  input logic             sum_bit,
  input logic             carry_out,
  input logic             done,
  input logic             addend_lsb
);

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (sum_word == '0 && !carry_out && !done));

  p_load_capture_r2: assert property (@(posedge clk) disable iff (rst)
    $past(load && !rst) |-> (sum_word == $past(augend_in) && !carry_out && !done));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load && !shift_en) |->
      ($stable(sum_word) && $stable(carry_out) && $stable(done)));

  p_done_freeze_r7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load && done) |-> (done && $stable(sum_word) && $stable(carry_out)));

  p_carry_majority_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load && shift_en && !done) |->
      (carry_out == (($past(sum_word[0]) & $past(addend_lsb)) |
                     (($past(sum_word[0]) ^ $past(addend_lsb)) & $past(carry_out)))));

  p_sum_enters_top_r8: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !load && shift_en && !done) |-> (sum_word[WIDTH-1] == $past(sum_bit)));

endmodule

bind serial_jk_adder serial_jk_adder_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .load(load), .shift_en(shift_en), .augend_in(augend_in),
  .sum_word(sum_word), .sum_bit(sum_bit), .carry_out(carry_out), .done(done),
  .addend_lsb(add_q[0])
);

// File: tb/serial_jk_adder_tb.sv
module serial_jk_adder_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, load = 1'b0, shift_en = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] sum_word;
  logic sum_bit, carry_out, done;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  serial_jk_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .load(load), .augend_in(a_in), .addend_in(b_in),
    .shift_en(shift_en), .sum_word(sum_word), .sum_bit(sum_bit),
    .carry_out(carry_out), .done(done));

  function automatic logic [W:0] low_sum(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [W:0] m = (k >= W) ? {1'b0, {W{1'b1}}} : ((W+1)'(1) << k) - 1'b1;
    return ({1'b0, a} & m) + ({1'b0, b} & m);
  endfunction

  function automatic logic [W-1:0] exp_word(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [W:0] s = low_sum(a, b, k);
    logic [W-1:0] lo = (k >= W) ? '0 : (a >> k);
    logic [W-1:0] hi = (k == 0) ? '0 : (s[W-1:0] << (W - k));
    return lo | hi;
  endfunction

  function automatic logic exp_carry(logic [W-1:0] a, logic [W-1:0] b, int k);
    logic [W:0] s = low_sum(a, b, k);
    return (k == 0) ? 1'b0 : s[k];
  endfunction

  task automatic chk(string req, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_load(logic [W-1:0] a, logic [W-1:0] b, bit with_shift);
    @(negedge clk);
    load = 1'b1; a_in = a; b_in = b; shift_en = with_shift;
    @(negedge clk);
    load = 1'b0; shift_en = 1'b0;
    chk(with_shift ? "R9 load wins" : "R2 word", {1'b0, sum_word}, {1'b0, a});
    chk("R2 carry/done", {carry_out, done}, 2'b00);
  endtask

  task automatic run_add(logic [W-1:0] a, logic [W-1:0] b, bit gaps);
    do_load(a, b, ($urandom % 4) == 0);
    for (int k = 1; k <= W; k++) begin
      if (gaps && ($urandom % 3) == 0) begin
        @(negedge clk);
        chk("R5 idle hold", {1'b0, sum_word}, {1'b0, exp_word(a, b, k - 1)});
        chk("R5 idle carry", {carry_out, done}, {exp_carry(a, b, k - 1), 1'b0});
      end
      shift_en = 1'b1;
      #1;
      chk("R4 sum_bit", sum_bit, a[k-1] ^ b[k-1] ^ exp_carry(a, b, k - 1));
      @(negedge clk);
      shift_en = 1'b0;
      chk("R8 partial word", {1'b0, sum_word}, {1'b0, exp_word(a, b, k)});
      chk("R6 carry", carry_out, exp_carry(a, b, k));
      chk("R3 done", done, k == W);
    end
    chk("R3 final sum", {carry_out, sum_word}, {1'b0, a} + {1'b0, b});
    shift_en = 1'b1;
    repeat (2) @(negedge clk);
    shift_en = 1'b0;
    chk("R7 frozen", {carry_out, sum_word}, {1'b0, a} + {1'b0, b});
    chk("R7 done held", done, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset word", {1'b0, sum_word}, '0);
    chk("R1 reset flags", {carry_out, done}, 2'b00);
    rst = 1'b0;
    run_add(8'h00, 8'h00, 0);
    run_add(8'hFF, 8'h01, 0);
    run_add(8'hFF, 8'hFF, 1);
    run_add(8'hAA, 8'h55, 0);
    run_add(8'h80, 8'h80, 1);
    for (int t = 0; t < 60; t++) run_add(W'($urandom), W'($urandom), 1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset after use", {carry_out, done, sum_word}, '0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule